// File: doc/BRIEF.md
# Run-Length Sample Expander

This block turns stored capture data back into a flat sample stream. The stored form is a sequence of 32-bit records. Each record holds three 8-bit channel-group values and a repeat byte. The block accepts one record at a time on a valid/ready input. It then plays that record out on a valid/ready output as a run of identical 32-bit samples. In each sample the fourth channel group is always zero.

A start pulse arms the block with an output budget, which is the largest number of samples it may emit in this run. A record whose run would overshoot the budget is cut short. Once the budget is used up the block stops, even if more records are waiting. The block also stops after it has fully expanded a record flagged as the last one. Throughout the run it shows how many samples it has written so far, and it raises a done flag when it stops.

Top module: `rle_expander`

## Requirements
- R1: Input record layout: group A in bits [7:0], group B in [15:8], group C in [23:16] and the repeat byte in [31:24]. Each output sample carries A in [7:0], B in [15:8] and C in [23:16].
- R2: A record with repeat byte N produces exactly N+1 output samples when the budget allows it. This holds from N=0 (one sample) up to N=255 (256 samples).
- R3: Bits [31:24] of every output sample are zero, whatever the input's bits [31:24] were.
- R4: When N+1 is larger than the remaining budget, the record emits only the remaining budget's worth of samples.
- R5: When the remaining budget reaches zero, `done` rises on the next cycle. From then on `in_ready` and `out_valid` stay low even while `in_valid` is high, and `samples_written` does not change.
- R6: `samples_written` goes up by one for each sample taken at the output (`out_valid` and `out_ready` both high on a clock edge). It never exceeds the loaded budget.
- R7: While a record is being expanded, `in_ready` is low. A new record is accepted only after the last sample of the previous one has been taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: When a record that was accepted with `in_last` high has had its final sample taken, `done` rises on the next cycle. After that no further records are accepted.
- R10: A `start` pulse loads `budget` as the remaining budget, clears `samples_written` and `done`, and makes the block ready for a record on the next cycle. A budget of zero makes `done` rise on the next cycle with no sample emitted.
- R11: After reset, `in_ready`, `out_valid` and `done` are low and `samples_written` is zero. No record is accepted until `start` has been pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that arms a new run |
| budget | input | 16 | Output sample budget, sampled on `start` |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Record will be accepted this cycle |
| in_data | input | 32 | Record: A, B, C, repeat byte from LSB up |
| in_last | input | 1 | Marks the record as the final one of the run |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Sink takes the sample this cycle |
| out_data | output | 32 | Expanded sample, top byte zero |
| samples_written | output | 16 | Samples taken since the last `start` |
| done | output | 1 | Run finished by budget or last marker |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume the sink is never handed an out-of-range budget: the budget fits in 16 bits, and a run never needs more than that many samples. The hold check on the output is only meaningful when `start` is low, so it is gated by `start`. The bench drives every input on the falling clock edge. It pulses `start` only between records or after `done`, and it only lowers `out_ready` while a sample is actually offered. This keeps all stimulus inside the handshake rules these checks rely on.

// File: rtl/rle_pkg.sv
package rle_pkg;
  parameter int unsigned GRP_W  = 8;
  parameter int unsigned N_GRP  = 4;
  parameter int unsigned WORD_W = GRP_W * N_GRP;
  parameter int unsigned CNT_W  = 16;
  localparam int unsigned REP_LSB = GRP_W * (N_GRP - 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [GRP_W-1:0]  grp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCEPT, ST_EXPAND, ST_DONE} state_t;

  // stored repeat field is one less than the run length
  function automatic cnt_t reps_of(grp_t rep);
    return {{(CNT_W-GRP_W){1'b0}}, rep} + cnt_t'(1);
  endfunction

  // run length limited by what is left of the budget
  function automatic cnt_t clip_reps(cnt_t want, cnt_t left);
    return (want > left) ? left : want;
  endfunction

  // keep the three value groups, force the top group to zero
  function automatic word_t pack_sample(word_t rec);
    word_t s;
    s = '0;
    for (int g = 0; g < int'(N_GRP) - 1; g++)
      s[g*GRP_W +: GRP_W] = rec[g*GRP_W +: GRP_W];
    return s;
  endfunction
endpackage

// File: rtl/rle_budget.sv
module rle_budget
  import rle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cnt_t load_val,
  input  logic take,
  output cnt_t remaining,
  output cnt_t written,
  output logic last_unit
);
  cnt_t budget_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      written   <= '0;
      budget_q  <= '0;
    end else if (load) begin
      remaining <= load_val;
      written   <= '0;
      budget_q  <= load_val;
    end else if (take) begin
      remaining <= remaining - cnt_t'(1);
      written   <= written + cnt_t'(1);
    end
  end

  assign last_unit = (remaining == cnt_t'(1));

  // R4
  budget_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> remaining != '0);
  // R6
  written_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    written + remaining == budget_q);
  // R6
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !load |=> written == $past(written) + cnt_t'(1));
endmodule

// File: rtl/rle_record.sv
module rle_record
  import rle_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  word_t rec_in,
  input  logic  last_in,
  input  cnt_t  remaining,
  input  logic  take,
  output word_t sample,
  output logic  final_sample,
  output logic  last_q
);
  word_t rec_q;
  cnt_t  rep_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q    <= '0;
      rep_left <= '0;
      last_q   <= 1'b0;
    end else if (capture) begin
      rec_q    <= rec_in;
      last_q   <= last_in;
      rep_left <= clip_reps(reps_of(rec_in[REP_LSB +: GRP_W]), remaining);
    end else if (take) begin
      rep_left <= rep_left - cnt_t'(1);
    end
  end

  assign sample       = pack_sample(rec_q);
  assign final_sample = (rep_left == cnt_t'(1));

  // R2
  rep_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> rep_left != '0);
  // R4
  clip_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |-> rep_left <= remaining);
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  budget,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  samples_written,
  output logic              done
);
  state_t state, state_nx;
  cnt_t   remaining;
  logic   last_unit, final_sample, last_q;
  logic   in_fire, out_fire, run_end;

  assign in_ready  = (state == ST_ACCEPT);
  assign out_valid = (state == ST_EXPAND);
  assign done      = (state == ST_DONE);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign run_end   = last_unit || last_q;

  always_comb begin
    state_nx = state;
    if (start)
      state_nx = (budget == '0) ? ST_DONE : ST_ACCEPT;
    else begin
      case (state)
        ST_ACCEPT: if (in_fire) state_nx = ST_EXPAND;
        ST_EXPAND: if (out_fire && final_sample)
                     state_nx = run_end ? ST_DONE : ST_ACCEPT;
        default:   state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  rle_budget u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_val  (budget),
    .take      (out_fire),
    .remaining (remaining),
    .written   (samples_written),
    .last_unit (last_unit)
  );

  rle_record u_record (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (in_fire),
    .rec_in       (in_data),
    .last_in      (in_last),
    .remaining    (remaining),
    .take         (out_fire),
    .sample       (out_data),
    .final_sample (final_sample),
    .last_q       (last_q)
  );

  // R7
  accept_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !start |=> out_valid && !in_ready);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_data));
  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && final_sample && last_q && !start |=> done);
  // R5
  budget_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && last_unit && !start |=> done);
  // R5
  done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(samples_written));
endmodule

// File: tb/sim_rle_expander.sv
module sim_rle_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] budget = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [15:0] samples_written;
  logic        done;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rle_expander u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .budget(budget),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .samples_written(samples_written), .done(done)
  );

  function automatic logic [31:0] mk_rec(logic [7:0] a, logic [7:0] b,
                                         logic [7:0] c, logic [7:0] rep);
    return {rep, c, b, a};
  endfunction

  function automatic logic [31:0] mk_smp(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return {8'h00, c, b, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; budget = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] rec, input bit last);
    int guard = 0;
    in_data = rec; in_last = last; in_valid = 1'b1;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // take n samples, each expected to equal exp; optional one-cycle stall each
  task automatic pull(input int n, input logic [31:0] exp, input bit stall,
                      input string req);
    int bad = 0;
    int held_bad = 0;
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      while (!out_valid && guard < 100) begin @(negedge clk); guard++; end
      if (!out_valid || out_data != exp) bad++;
      if (stall) begin
        out_ready = 1'b0;
        @(negedge clk);
        if (!out_valid || out_data != exp) held_bad++;
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(bad == 0, req, "sample value/count", bad, 0);
    if (stall) chk(held_bad == 0, "R8", "held sample under backpressure", held_bad, 0);
  endtask

  task automatic t_reset();
    // R11
    chk(!in_ready && !out_valid && !done, "R11", "handshake/done after reset",
        {in_ready, out_valid, done}, 0);
    chk(samples_written == 0, "R11", "written after reset", samples_written, 0);
    in_data = mk_rec(8'h1, 8'h2, 8'h3, 8'h0); in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid, "R11", "no accept before start", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_basic();
    do_start(16'd100);
    chk(samples_written == 0 && !done && in_ready, "R10", "armed after start",
        {samples_written, done, in_ready}, 1);
    send(mk_rec(8'h11, 8'h22, 8'h33, 8'd2), 1'b0);
    chk(out_valid && !in_ready, "R7", "input stalled during run", in_ready, 0);
    chk(out_data == 32'h0033_2211, "R1", "group placement", out_data, 32'h0033_2211);
    pull(3, mk_smp(8'h11, 8'h22, 8'h33), 1'b0, "R2");
    chk(!out_valid && in_ready, "R2", "run of exactly 3", out_valid, 0);
    chk(samples_written == 3, "R6", "written after 3", samples_written, 3);
  endtask

  task automatic t_stall();
    send(mk_rec(8'hA5, 8'h5A, 8'hC3, 8'd1), 1'b0);
    // R3: top byte is zero even though repeat byte is nonzero
    chk(out_data[31:24] == 8'h00, "R3", "zero top group", out_data[31:24], 0);
    pull(2, mk_smp(8'hA5, 8'h5A, 8'hC3), 1'b1, "R8");
    chk(samples_written == 5, "R6", "written after 5", samples_written, 5);
  endtask

  task automatic t_last();
    send(mk_rec(8'h01, 8'hFF, 8'h80, 8'd0), 1'b1);
    pull(1, mk_smp(8'h01, 8'hFF, 8'h80), 1'b0, "R2");
    chk(done && !in_ready, "R9", "done after last record", done, 1);
    chk(samples_written == 6, "R6", "written after last", samples_written, 6);
  endtask

  task automatic t_clip();
    do_start(16'd5);
    send(mk_rec(8'h10, 8'h20, 8'h30, 8'd2), 1'b0);
    pull(3, mk_smp(8'h10, 8'h20, 8'h30), 1'b0, "R2");
    send(mk_rec(8'h44, 8'h55, 8'h66, 8'd9), 1'b0);
    pull(2, mk_smp(8'h44, 8'h55, 8'h66), 1'b0, "R4");
    chk(done && !out_valid, "R4", "run clipped to 2", out_valid, 0);
    chk(samples_written == 5, "R5", "written equals budget", samples_written, 5);
    in_data = mk_rec(8'h77, 8'h77, 8'h77, 8'd3); in_valid = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (in_ready || out_valid) seen++;
      end
      chk(seen == 0, "R5", "input ignored after budget", seen, 0);
    end
    in_valid = 1'b0;
    chk(samples_written == 5 && done, "R5", "written frozen", samples_written, 5);
  endtask

  task automatic t_zero();
    do_start(16'd0);
    chk(done && !in_ready && samples_written == 0, "R10", "zero budget done",
        {done, in_ready}, 2);
  endtask

  task automatic t_long();
    do_start(16'd300);
    chk(!done && in_ready && samples_written == 0, "R10", "restart clears",
        {done, samples_written}, 0);
    send(mk_rec(8'hDE, 8'hAD, 8'hBE, 8'd255), 1'b0);
    pull(256, mk_smp(8'hDE, 8'hAD, 8'hBE), 1'b0, "R2");
    chk(in_ready && !out_valid, "R2", "run of 256 ends", in_ready, 1);
    chk(samples_written == 256, "R6", "written after 256", samples_written, 256);
    do_start(16'd4);
    send(mk_rec(8'h0F, 8'hF0, 8'h3C, 8'd255), 1'b0);
    pull(4, mk_smp(8'h0F, 8'hF0, 8'h3C), 1'b0, "R4");
    chk(done && samples_written == 4, "R4", "long run clipped to 4", samples_written, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_last();
    t_clip();
    t_zero();
    t_long();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule